// File: doc/BRIEF.md
# ADPCM Codec Frame Interface

This block runs the serial link to an external 4-bit ADPCM voice codec. From a 19.2 MHz system clock it makes a 600 kHz codec bit clock and an 8 kHz frame sync. In each frame it moves one 4-bit sample in each direction.

Toward the codec, a receive nibble is taken from an internal receive FIFO at the start of each frame and shifted out on a data line. The de-spreader side fills that FIFO. From the codec, four transmit bits are sampled during the sync pulse, packed into a nibble and written into an internal transmit FIFO. The spreader side drains that FIFO.

Each FIFO shows full and empty status. Two sticky flags record a frame that found the receive FIFO empty and a transmit nibble that was dropped because the transmit FIFO was full.

Top module: `codec_frame_if`

## Requirements
- R1: While reset is held and until the first codec-clock rise, codecClk, codecSync and codecDout are 0, rxEmpty and txEmpty are 1, and rxFull, txFull, rxUnderflow and txOverflow are 0.
- R2: codecClk is the system clock divided by 32. It is high for 16 system cycles and low for 16. Its first rise comes on the 16th system clock edge after reset is released.
- R3: A frame lasts 75 codec-clock periods (2400 system cycles). codecSync rises together with the codec-clock rise that opens the frame and stays high for exactly 4 codec-clock periods (128 system cycles).
- R4: At the frame-opening rise, one nibble is popped from the receive FIFO. Its bits appear on codecDout most significant bit first, one per codec-clock rise, over the four sync periods. codecDout is 0 whenever codecSync is low.
- R5: If the receive FIFO is empty at the frame-opening rise, codecDout stays 0 for the whole frame and rxUnderflow is set. rxUnderflow stays set until reset.
- R6: codecDin is sampled on the four codec-clock falls while codecSync is high. The first sample is the most significant bit. The completed nibble is written into the transmit FIFO on the fourth fall.
- R7: If the transmit FIFO is full when a nibble completes, the nibble is dropped and the FIFO contents are unchanged. txOverflow is set and stays set until reset.
- R8: Each FIFO holds 8 nibbles in first-in first-out order. Full is asserted at 8 entries and empty at 0. A push while full and a pop while empty are ignored. txData shows the oldest entry while txEmpty is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 19.2 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| codecDin | input | 1 | Serial transmit data from the codec |
| rxPush | input | 1 | Write strobe for the receive FIFO |
| rxData | input | 4 | Nibble written into the receive FIFO |
| txPop | input | 1 | Read strobe for the transmit FIFO |
| codecClk | output | 1 | 600 kHz codec bit clock |
| codecSync | output | 1 | 8 kHz frame sync, high for four bit periods |
| codecDout | output | 1 | Serial receive data to the codec |
| rxFull | output | 1 | Receive FIFO holds 8 nibbles |
| rxEmpty | output | 1 | Receive FIFO holds no nibble |
| txData | output | 4 | Oldest nibble in the transmit FIFO |
| txFull | output | 1 | Transmit FIFO holds 8 nibbles |
| txEmpty | output | 1 | Transmit FIFO holds no nibble |
| rxUnderflow | output | 1 | Sticky: a frame began with the receive FIFO empty |
| txOverflow | output | 1 | Sticky: a transmit nibble was dropped on a full FIFO |

## Verification
The bench builds the block with its default parameters: a 16-cycle half period, 75-bit frames, 4-bit nibbles and 8-deep FIFOs. With these values it measures the real 2400-cycle frame and the 128-cycle sync pulse. A frame takes only 2400 cycles, so thirty or more whole frames fit in the run. That is enough to fill and drain each 8-deep FIFO through the serial lines, and to reach the dropped ninth transmit nibble and the ninth, empty receive frame.

// File: rtl/codec_if_pkg.sv
package codec_if_pkg;

  // Strobes from the frame control to the datapath, valid for one system cycle
  typedef struct packed {
    logic frameStart;  // codec-clock rise opening a frame
    logic rxShift;     // any other codec-clock rise
    logic txCapture;   // codec-clock fall inside the sync window
    logic txComplete;  // last such fall: nibble is complete
  } codec_strobe_t;

endpackage

// File: rtl/codec_nib_fifo.sv
module codec_nib_fifo #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             full,
  output logic             empty
);

  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [AW-1:0]    LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  assign full     = (count == FULL_CNT);
  assign empty    = (count == '0);
  assign doPush   = push && !full;
  assign doPop    = pop && !empty;
  assign headData = mem[rdPtr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/codec_if_ctrl.sv
module codec_if_ctrl
  import codec_if_pkg::*;
#(
  parameter int CLK_HALF  = 16,
  parameter int FRAME_LEN = 75,
  parameter int SYNC_LEN  = 4
) (
  input  logic          clk,
  input  logic          rst,
  output logic          codecClk,
  output logic          codecSync,
  output codec_strobe_t stb
);

  localparam int DIV_W = $clog2(2 * CLK_HALF);
  localparam int BIT_W = $clog2(FRAME_LEN);
  localparam logic [DIV_W-1:0] RISE_AT  = DIV_W'(CLK_HALF - 1);
  localparam logic [DIV_W-1:0] FALL_AT  = DIV_W'(2 * CLK_HALF - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_LEN - 1);
  localparam logic [BIT_W-1:0] SYNC_END = BIT_W'(SYNC_LEN);
  localparam logic [BIT_W-1:0] SYNC_TOP = BIT_W'(SYNC_LEN - 1);

  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt, nextBit;
  logic             riseNow, fallNow;

  assign riseNow = (divCnt == RISE_AT);
  assign fallNow = (divCnt == FALL_AT);
  assign nextBit = (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;

  // Divider and bit position; the bit counter parks at the last bit so the
  // first rise after reset opens frame zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt    <= '0;
      codecClk  <= 1'b0;
      bitCnt    <= LAST_BIT;
      codecSync <= 1'b0;
    end else begin
      divCnt <= fallNow ? '0 : divCnt + 1'b1;
      if (riseNow) begin
        codecClk  <= 1'b1;
        bitCnt    <= nextBit;
        codecSync <= (nextBit < SYNC_END);
      end else if (fallNow) begin
        codecClk <= 1'b0;
      end
    end
  end

  always_comb begin
    stb.frameStart = riseNow && (nextBit == '0);
    stb.rxShift    = riseNow && (nextBit != '0);
    stb.txCapture  = fallNow && (bitCnt < SYNC_END);
    stb.txComplete = fallNow && (bitCnt == SYNC_TOP);
  end

endmodule

// File: rtl/codec_if_dp.sv
module codec_if_dp
  import codec_if_pkg::*;
#(
  parameter int NIB_W      = 4,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  codec_strobe_t    stb,
  input  logic             codecDin,
  output logic             codecDout,
  input  logic             rxPush,
  input  logic [NIB_W-1:0] rxData,
  output logic             rxFull,
  output logic             rxEmpty,
  input  logic             txPop,
  output logic [NIB_W-1:0] txData,
  output logic             txFull,
  output logic             txEmpty,
  output logic             rxUnderflow,
  output logic             txOverflow
);

  logic [NIB_W-1:0] rxHead, rxShiftReg, txNibble;
  logic [NIB_W-2:0] txShiftReg;
  logic             rxPopInt;

  assign rxPopInt  = stb.frameStart && !rxEmpty;
  assign txNibble  = {txShiftReg, codecDin};
  assign codecDout = rxShiftReg[NIB_W-1];

  codec_nib_fifo #(.WIDTH(NIB_W), .DEPTH(FIFO_DEPTH)) u_rxFifo (
    .clk      (clk),
    .rst      (rst),
    .push     (rxPush),
    .pushData (rxData),
    .pop      (rxPopInt),
    .headData (rxHead),
    .full     (rxFull),
    .empty    (rxEmpty)
  );

  codec_nib_fifo #(.WIDTH(NIB_W), .DEPTH(FIFO_DEPTH)) u_txFifo (
    .clk      (clk),
    .rst      (rst),
    .push     (stb.txComplete),
    .pushData (txNibble),
    .pop      (txPop),
    .headData (txData),
    .full     (txFull),
    .empty    (txEmpty)
  );

  // Outgoing nibble: loaded at frame start, shifted left with zero fill
  always_ff @(posedge clk) begin
    if (rst) begin
      rxShiftReg  <= '0;
      rxUnderflow <= 1'b0;
    end else if (stb.frameStart) begin
      rxShiftReg <= rxEmpty ? '0 : rxHead;
      if (rxEmpty) rxUnderflow <= 1'b1;
    end else if (stb.rxShift) begin
      rxShiftReg <= {rxShiftReg[NIB_W-2:0], 1'b0};
    end
  end

  // Incoming nibble: first sampled bit ends up most significant
  always_ff @(posedge clk) begin
    if (rst) begin
      txShiftReg <= '0;
      txOverflow <= 1'b0;
    end else begin
      if (stb.txCapture && !stb.txComplete)
        txShiftReg <= txNibble[NIB_W-2:0];
      if (stb.txComplete && txFull)
        txOverflow <= 1'b1;
    end
  end

endmodule

// File: rtl/codec_frame_if.sv
module codec_frame_if
  import codec_if_pkg::*;
#(
  parameter int CLK_HALF   = 16,
  parameter int FRAME_LEN  = 75,
  parameter int NIB_W      = 4,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             codecDin,
  input  logic             rxPush,
  input  logic [NIB_W-1:0] rxData,
  input  logic             txPop,
  output logic             codecClk,
  output logic             codecSync,
  output logic             codecDout,
  output logic             rxFull,
  output logic             rxEmpty,
  output logic [NIB_W-1:0] txData,
  output logic             txFull,
  output logic             txEmpty,
  output logic             rxUnderflow,
  output logic             txOverflow
);

  localparam int SYNC_LEN = NIB_W;

  codec_strobe_t stb;

  codec_if_ctrl #(
    .CLK_HALF  (CLK_HALF),
    .FRAME_LEN (FRAME_LEN),
    .SYNC_LEN  (SYNC_LEN)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .codecClk  (codecClk),
    .codecSync (codecSync),
    .stb       (stb)
  );

  codec_if_dp #(
    .NIB_W      (NIB_W),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .stb         (stb),
    .codecDin    (codecDin),
    .codecDout   (codecDout),
    .rxPush      (rxPush),
    .rxData      (rxData),
    .rxFull      (rxFull),
    .rxEmpty     (rxEmpty),
    .txPop       (txPop),
    .txData      (txData),
    .txFull      (txFull),
    .txEmpty     (txEmpty),
    .rxUnderflow (rxUnderflow),
    .txOverflow  (txOverflow)
  );

endmodule

// File: rtl/codec_frame_if_chk.sv
module codec_frame_if_chk #(
  parameter int CLK_HALF = 16
) (
  input logic clk,
  input logic rst,
  input logic codecClk,
  input logic codecSync,
  input logic codecDout,
  input logic rxFull,
  input logic rxEmpty,
  input logic txFull,
  input logic txEmpty,
  input logic rxUnderflow,
  input logic txOverflow
);

  localparam int CW = $clog2(CLK_HALF + 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(CLK_HALF - 1);

  // Free-running half-period counter, independent of the design's divider
  logic [CW-1:0] halfCnt;
  always_ff @(posedge clk) begin
    if (rst) halfCnt <= '0;
    else     halfCnt <= (halfCnt == HALF_LAST) ? '0 : halfCnt + 1'b1;
  end

  a_r2_toggle_on_time: assert property (@(posedge clk) disable iff (rst)
    (halfCnt == HALF_LAST) |=> !$stable(codecClk));

  a_r2_steady_between: assert property (@(posedge clk) disable iff (rst)
    (halfCnt != HALF_LAST) |=> $stable(codecClk));

  a_r3_sync_moves_on_rise: assert property (@(posedge clk) disable iff (rst)
    !$stable(codecSync) |-> $rose(codecClk));

  a_r4_dout_moves_on_rise: assert property (@(posedge clk) disable iff (rst)
    !$stable(codecDout) |-> $rose(codecClk));

  a_r4_dout_quiet_outside_sync: assert property (@(posedge clk) disable iff (rst)
    !codecSync |-> !codecDout);

  a_r5_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
    rxUnderflow |=> rxUnderflow);

  a_r5_underflow_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(rxUnderflow) |-> ($rose(codecSync) && $past(rxEmpty)));

  a_r6_push_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(txEmpty) |-> $fell(codecClk));

  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    txOverflow |=> txOverflow);

  a_r7_overflow_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(txOverflow) |-> ($fell(codecClk) && $past(txFull)));

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rxFull && rxEmpty) && !(txFull && txEmpty));

endmodule

bind codec_frame_if codec_frame_if_chk #(.CLK_HALF(CLK_HALF)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .codecClk    (codecClk),
  .codecSync   (codecSync),
  .codecDout   (codecDout),
  .rxFull      (rxFull),
  .rxEmpty     (rxEmpty),
  .txFull      (txFull),
  .txEmpty     (txEmpty),
  .rxUnderflow (rxUnderflow),
  .txOverflow  (txOverflow)
);

// File: tb/codec_frame_if_tb.sv
`timescale 1ns/1ps
module codec_frame_if_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       codecDin = 1'b0;
  logic       rxPush = 1'b0;
  logic [3:0] rxData = '0;
  logic       txPop = 1'b0;
  logic       codecClk, codecSync, codecDout;
  logic       rxFull, rxEmpty, txFull, txEmpty, rxUnderflow, txOverflow;
  logic [3:0] txData;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  codec_frame_if u_dut (
    .clk(clk), .rst(rst), .codecDin(codecDin), .rxPush(rxPush), .rxData(rxData),
    .txPop(txPop), .codecClk(codecClk), .codecSync(codecSync), .codecDout(codecDout),
    .rxFull(rxFull), .rxEmpty(rxEmpty), .txData(txData), .txFull(txFull),
    .txEmpty(txEmpty), .rxUnderflow(rxUnderflow), .txOverflow(txOverflow)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic applyReset();
    rst = 1'b1; rxPush = 1'b0; txPop = 1'b0; codecDin = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Acts as the codec for one frame: drives txNib, collects the received nibble
  task automatic runFrame(input logic [3:0] txNib, output logic [3:0] rxNib);
    @(posedge codecSync);
    codecDin = txNib[3];
    for (int k = 0; k < 4; k++) begin
      if (k > 0) begin
        @(posedge codecClk);
        codecDin = txNib[3-k];
      end
      @(negedge codecClk);
      @(negedge clk);
      rxNib[3-k] = codecDout;
    end
    @(posedge codecClk);
    codecDin = 1'b0;
    @(negedge clk);
    check(codecDout == 1'b0 && codecSync == 1'b0, "R4", "dout after sync window",
          int'(codecDout), 0);
  endtask

  task automatic popTx(output logic [3:0] nib);
    nib = txData;
    txPop = 1'b1;
    @(negedge clk);
    txPop = 1'b0;
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(codecClk == 0 && codecSync == 0 && codecDout == 0, "R1", "lines in reset",
          int'({codecClk, codecSync, codecDout}), 0);
    check(rxEmpty == 1 && txEmpty == 1, "R1", "empty in reset", int'({rxEmpty, txEmpty}), 3);
    check(rxFull == 0 && txFull == 0, "R1", "full in reset", int'({rxFull, txFull}), 0);
    check(rxUnderflow == 0 && txOverflow == 0, "R1", "flags in reset",
          int'({rxUnderflow, txOverflow}), 0);
  endtask

  task automatic testClock();
    int n = 0;
    int h = 0;
    int l = 0;
    applyReset();
    while (!codecClk) begin
      @(negedge clk);
      n++;
    end
    check(n == 16, "R2", "cycles to first rise", n, 16);
    check(codecSync == 1'b1, "R3", "sync with first rise", int'(codecSync), 1);
    while (codecClk) begin
      @(negedge clk);
      h++;
    end
    while (!codecClk) begin
      @(negedge clk);
      l++;
    end
    check(h == 16, "R2", "high cycles", h, 16);
    check(l == 16, "R2", "low cycles", l, 16);
  endtask

  task automatic testFrame();
    int n = 0;
    int high = 0;
    bit prev = 1'b1;
    @(posedge codecSync);
    forever begin
      @(negedge clk);
      if (codecSync && !prev) break;
      n++;
      if (codecSync) high++;
      prev = codecSync;
    end
    check(n == 2400, "R3", "frame length in cycles", n, 2400);
    check(high == 128, "R3", "sync high cycles", high, 128);
  endtask

  task automatic testRxPath();
    logic [3:0] got;
    applyReset();
    rxPush = 1'b1; rxData = 4'hA;
    @(negedge clk);
    rxData = 4'h5;
    @(negedge clk);
    rxPush = 1'b0;
    runFrame(4'h0, got);
    check(got == 4'hA, "R4", "first nibble msb first", int'(got), 10);
    runFrame(4'h0, got);
    check(got == 4'h5, "R4", "second nibble", int'(got), 5);
    check(rxUnderflow == 1'b0, "R5", "no underflow with data", int'(rxUnderflow), 0);
    runFrame(4'h0, got);
    check(got == 4'h0, "R5", "zeros on empty frame", int'(got), 0);
    check(rxUnderflow == 1'b1, "R5", "underflow set", int'(rxUnderflow), 1);
    runFrame(4'h0, got);
    check(rxUnderflow == 1'b1, "R5", "underflow sticky", int'(rxUnderflow), 1);
  endtask

  task automatic testTxPath();
    logic [3:0] got;
    logic [3:0] nib;
    applyReset();
    check(txEmpty == 1'b1, "R6", "tx empty before frame", int'(txEmpty), 1);
    runFrame(4'h6, got);
    check(txEmpty == 1'b0, "R6", "nibble written after frame", int'(txEmpty), 0);
    runFrame(4'h9, got);
    popTx(nib);
    check(nib == 4'h6, "R6", "first captured nibble", int'(nib), 6);
    popTx(nib);
    check(nib == 4'h9, "R6", "second captured nibble", int'(nib), 9);
    check(txEmpty == 1'b1, "R8", "tx empty after pops", int'(txEmpty), 1);
    popTx(nib);
    check(txEmpty == 1'b1 && txFull == 1'b0, "R8", "pop on empty ignored",
          int'({txEmpty, txFull}), 2);
  endtask

  task automatic testOverflow();
    logic [3:0] got;
    logic [3:0] nib;
    applyReset();
    for (int k = 0; k < 8; k++) runFrame(4'(k + 1), got);
    check(txFull == 1'b1, "R8", "tx full after eight", int'(txFull), 1);
    check(txOverflow == 1'b0, "R7", "no overflow yet", int'(txOverflow), 0);
    runFrame(4'hF, got);
    check(txOverflow == 1'b1, "R7", "overflow set", int'(txOverflow), 1);
    for (int k = 0; k < 8; k++) begin
      popTx(nib);
      check(nib == 4'(k + 1), "R7", "contents kept on overflow", int'(nib), k + 1);
    end
    check(txEmpty == 1'b1, "R7", "dropped nibble absent", int'(txEmpty), 1);
    check(txOverflow == 1'b1, "R7", "overflow sticky", int'(txOverflow), 1);
  endtask

  task automatic testRxFull();
    logic [3:0] got;
    applyReset();
    for (int k = 0; k < 8; k++) begin
      rxPush = 1'b1;
      rxData = 4'(k + 1);
      @(negedge clk);
    end
    rxPush = 1'b0;
    check(rxFull == 1'b1, "R8", "rx full after eight", int'(rxFull), 1);
    rxPush = 1'b1; rxData = 4'hF;
    @(negedge clk);
    rxPush = 1'b0;
    check(rxFull == 1'b1, "R8", "rx still full after extra push", int'(rxFull), 1);
    for (int k = 0; k < 8; k++) begin
      runFrame(4'h0, got);
      check(got == 4'(k + 1), "R8", "rx fifo order", int'(got), k + 1);
    end
    check(rxEmpty == 1'b1, "R8", "rx empty after eight frames", int'(rxEmpty), 1);
    runFrame(4'h0, got);
    check(got == 4'h0, "R8", "push on full dropped", int'(got), 0);
  endtask

  initial begin
    testReset();
    testClock();
    testFrame();
    testRxPath();
    testTxPath();
    testOverflow();
    testRxFull();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule